// File: doc/BRIEF.md
# Dual Serial-Port FIFO with DMA Request Thresholds

This block sits between a serial engine and a DMA controller and holds two independent queues of 16-bit words: a transmit queue, filled by DMA and drained by the serial engine, and a receive queue, filled by the serial engine and drained by DMA. Both sides of each queue are valid/ready streams. A word moves on a rising clock edge only when valid and ready are both high. The write side drops `in_ready` while its queue is full. The read side raises `out_valid` while its queue holds a word, and it presents the oldest word at once, without waiting for a pop.

Each direction has its own DMA request, enable bit and 3-bit threshold field. The transmit request counts free slots and the receive request counts occupied slots. In both fields a value of L stands for L+1 entries. The thresholds are held in a small configuration store that loads through a level-write strobe. The enables load through a separate enable-write strobe, so either can change without touching the other. Each queue has a flush strobe and a 4-bit occupancy output. A push to a full queue or a pop from an empty one is refused and reported by a one-cycle error pulse.

Top module: `dual_fifo_dma`

## Requirements
- R1: On each write side, `in_ready` is high exactly when the queue holds fewer than 8 words. A word is stored on a rising edge where `in_valid` and `in_ready` are both high and no flush is requested.
- R2: On each read side, `out_valid` is high exactly when the queue is non-empty. `out_data` shows the oldest stored word, and words leave in the order they were accepted, one per edge where `out_valid` and `out_ready` are high and no flush is requested.
- R3: `tx_cnt` and `rx_cnt` report the current occupancy of their queue (0 to 8), following each push and pop one edge later. A simultaneous push and pop leaves the count unchanged.
- R4: A flush strobe high at an edge sets that queue's count to 0 after that edge. A push or pop in the same cycle is dropped, and the other queue is unaffected.
- R5: `tx_dma_req` equals `tx_en AND (8 - tx_cnt >= tx_lvl + 1)`, a level that follows the count and configuration.
- R6: `rx_dma_req` equals `rx_en AND (rx_cnt >= rx_lvl + 1)`, a level that follows the count and configuration.
- R7: After reset both counts are 0, both thresholds are 7, both enables are 0, and both requests and both error outputs are low.
- R8: With no flush requested, a push attempt (`in_valid` high) while full or a pop attempt (`out_ready` high) while empty leaves contents and count unchanged and raises that queue's `*_err` for exactly the following cycle.
- R9: `lvl_wr` loads both thresholds from `tx_lvl_in`/`rx_lvl_in`, and `en_wr` loads both enables from `tx_en_in`/`rx_en_in`. Each strobe leaves the other fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit write-side valid (from DMA) |
| tx_in_ready | output | 1 | Transmit write-side ready |
| tx_in_data | input | 16 | Transmit word to store |
| tx_out_valid | output | 1 | Transmit read-side valid (to serial engine) |
| tx_out_ready | input | 1 | Transmit read-side ready |
| tx_out_data | output | 16 | Oldest transmit word |
| rx_in_valid | input | 1 | Receive write-side valid (from serial engine) |
| rx_in_ready | output | 1 | Receive write-side ready |
| rx_in_data | input | 16 | Receive word to store |
| rx_out_valid | output | 1 | Receive read-side valid (to DMA) |
| rx_out_ready | input | 1 | Receive read-side ready |
| rx_out_data | output | 16 | Oldest receive word |
| tx_flush | input | 1 | Transmit queue flush strobe |
| rx_flush | input | 1 | Receive queue flush strobe |
| lvl_wr | input | 1 | Load both threshold fields |
| tx_lvl_in | input | 3 | Transmit threshold (free slots minus one) |
| rx_lvl_in | input | 3 | Receive threshold (filled slots minus one) |
| en_wr | input | 1 | Load both DMA enables |
| tx_en_in | input | 1 | Transmit DMA enable value |
| rx_en_in | input | 1 | Receive DMA enable value |
| tx_cnt | output | 4 | Transmit occupancy |
| rx_cnt | output | 4 | Receive occupancy |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |
| tx_err | output | 1 | Transmit refused-access pulse |
| rx_err | output | 1 | Receive refused-access pulse |

## Verification
The bench builds the block with its defaults: 16-bit words, depth 8 and 3-bit threshold fields. With these values every threshold code from 0 to 7 corresponds to a reachable count on both sides, including the boundaries where the transmit request needs a completely empty queue and the receive request needs a completely full one. Random phases that favour filling, favouring draining or balance drive both queues to full and empty. There they meet refused pushes and pops, flushes that collide with traffic, and threshold and enable writes that arrive in the middle of traffic.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
  typedef enum logic {
    REQ_ON_FREE   = 1'b0,
    REQ_ON_FILLED = 1'b1
  } req_mode_e;
endpackage

// File: rtl/dfd_fifo.sv
module dfd_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CW-1:0]     count,
  output logic              err
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt_q;
  logic              full, empty, push, pop, err_q;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign push      = in_valid && !full && !flush;
  assign pop       = out_ready && !empty && !flush;
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign count     = cnt_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= !flush && ((in_valid && full) || (out_ready && empty));
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        cnt_q  <= '0;
      end else begin
        if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        unique case ({push, pop})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R4
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R8
  full_push_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready && !flush) |=> ($stable(count) && err));
  // R8
  empty_pop_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && out_ready && !in_valid && !flush) |=> (count == '0 && err));
endmodule

// File: rtl/dfd_req.sv
module dfd_req
  import dfd_pkg::*;
#(
  parameter int        DEPTH = 8,
  parameter int        CW    = 4,
  parameter int        LW    = 3,
  parameter req_mode_e MODE  = REQ_ON_FREE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [LW-1:0] lvl,
  input  logic          en,
  output logic          req
);
  logic [CW-1:0] measure;
  logic [CW-1:0] thresh;

  assign thresh = CW'(lvl) + CW'(1);

  generate
    if (MODE == REQ_ON_FREE) begin : g_free
      assign measure = CW'(DEPTH) - count;
      // R5
      empty_tx_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == '0) |-> req);
    end else begin : g_filled
      assign measure = count;
      // R6
      full_rx_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == CW'(DEPTH)) |-> req);
    end
  endgenerate

  assign req = en && (measure >= thresh);

  // R5 R6
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> en);
endmodule

// File: rtl/dual_fifo_dma.sv
module dual_fifo_dma
  import dfd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int LW    = $clog2(DEPTH),
  localparam int CW    = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic              lvl_wr,
  input  logic [LW-1:0]     tx_lvl_in,
  input  logic [LW-1:0]     rx_lvl_in,
  input  logic              en_wr,
  input  logic              tx_en_in,
  input  logic              rx_en_in,
  output logic [CW-1:0]     tx_cnt,
  output logic [CW-1:0]     rx_cnt,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              tx_err,
  output logic              rx_err
);
  logic [LW-1:0] tx_lvl_q, rx_lvl_q;
  logic          tx_en_q, rx_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lvl_q <= '1;
      rx_lvl_q <= '1;
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
    end else begin
      if (lvl_wr) begin
        tx_lvl_q <= tx_lvl_in;
        rx_lvl_q <= rx_lvl_in;
      end
      if (en_wr) begin
        tx_en_q <= tx_en_in;
        rx_en_q <= rx_en_in;
      end
    end
  end

  dfd_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .count(tx_cnt), .err(tx_err));

  dfd_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_cnt), .err(rx_err));

  dfd_req #(.DEPTH(DEPTH), .CW(CW), .LW(LW), .MODE(REQ_ON_FREE)) u_tx_req (
    .clk(clk), .rst_n(rst_n), .count(tx_cnt), .lvl(tx_lvl_q), .en(tx_en_q),
    .req(tx_dma_req));

  dfd_req #(.DEPTH(DEPTH), .CW(CW), .LW(LW), .MODE(REQ_ON_FILLED)) u_rx_req (
    .clk(clk), .rst_n(rst_n), .count(rx_cnt), .lvl(rx_lvl_q), .en(rx_en_q),
    .req(rx_dma_req));

  // R9
  disable_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !tx_en_in && !rx_en_in) |=> (!tx_dma_req && !rx_dma_req));
  // R4
  flush_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !rx_flush && !rx_in_valid && !rx_out_ready) |=> $stable(rx_cnt));
endmodule

// File: tb/tb_dual_fifo_dma.sv
`timescale 1ns/1ps
module tb_dual_fifo_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // index 0 = transmit queue, index 1 = receive queue
  logic        in_v  [2];
  logic        out_r [2];
  logic [15:0] in_d  [2];
  logic        fl    [2];
  logic [2:0]  lvl_in[2];
  logic        en_in [2];
  logic        lvl_wr, en_wr;

  logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [15:0] tx_out_data, rx_out_data;
  logic [3:0]  tx_cnt, rx_cnt;
  logic        tx_dma_req, rx_dma_req, tx_err, rx_err;

  dual_fifo_dma dut (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(in_v[0]), .tx_in_ready(tx_in_ready), .tx_in_data(in_d[0]),
    .tx_out_valid(tx_out_valid), .tx_out_ready(out_r[0]), .tx_out_data(tx_out_data),
    .rx_in_valid(in_v[1]), .rx_in_ready(rx_in_ready), .rx_in_data(in_d[1]),
    .rx_out_valid(rx_out_valid), .rx_out_ready(out_r[1]), .rx_out_data(rx_out_data),
    .tx_flush(fl[0]), .rx_flush(fl[1]),
    .lvl_wr(lvl_wr), .tx_lvl_in(lvl_in[0]), .rx_lvl_in(lvl_in[1]),
    .en_wr(en_wr), .tx_en_in(en_in[0]), .rx_en_in(en_in[1]),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_dma_req(tx_dma_req),
    .rx_dma_req(rx_dma_req), .tx_err(tx_err), .rx_err(rx_err));

  // reference model
  logic [15:0] m_buf [2][8];
  int          m_cnt [2];
  logic        m_err [2];
  int          m_lvl [2];
  logic        m_en  [2];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_req(int s);
    if (!m_en[s]) return 1'b0;
    if (s == 0) return (8 - m_cnt[0]) >= m_lvl[0] + 1; // R5 free slots
    return m_cnt[1] >= m_lvl[1] + 1;                    // R6 filled slots
  endfunction

  task automatic check_all(string ctx);
    cmp({ctx, " R1 tx ready"}, tx_in_ready, m_cnt[0] < 8);
    cmp({ctx, " R1 rx ready"}, rx_in_ready, m_cnt[1] < 8);
    cmp({ctx, " R2 tx valid"}, tx_out_valid, m_cnt[0] > 0);
    cmp({ctx, " R2 rx valid"}, rx_out_valid, m_cnt[1] > 0);
    if (m_cnt[0] > 0) cmp({ctx, " R2 tx data"}, tx_out_data, m_buf[0][0]);
    if (m_cnt[1] > 0) cmp({ctx, " R2 rx data"}, rx_out_data, m_buf[1][0]);
    cmp({ctx, " R3 R4 tx count"}, tx_cnt, m_cnt[0]);
    cmp({ctx, " R3 R4 rx count"}, rx_cnt, m_cnt[1]);
    cmp({ctx, " R5 R9 tx req"}, tx_dma_req, exp_req(0));
    cmp({ctx, " R6 R9 rx req"}, rx_dma_req, exp_req(1));
    cmp({ctx, " R8 tx err"}, tx_err, m_err[0]);
    cmp({ctx, " R8 rx err"}, rx_err, m_err[1]);
  endtask

  task automatic model_next();
    for (int s = 0; s < 2; s++) begin
      bit full  = (m_cnt[s] == 8);
      bit empty = (m_cnt[s] == 0);
      if (fl[s]) begin
        m_cnt[s] = 0;
        m_err[s] = 1'b0;
      end else begin
        m_err[s] = (in_v[s] && full) || (out_r[s] && empty);
        if (out_r[s] && !empty) begin
          for (int k = 0; k < 7; k++) m_buf[s][k] = m_buf[s][k+1];
          m_cnt[s]--;
        end
        if (in_v[s] && !full) begin
          m_buf[s][m_cnt[s]] = in_d[s];
          m_cnt[s]++;
        end
      end
      if (lvl_wr) m_lvl[s] = int'(lvl_in[s]);
      if (en_wr)  m_en[s]  = en_in[s];
    end
  endtask

  task automatic idle();
    for (int s = 0; s < 2; s++) begin
      in_v[s] = 0; out_r[s] = 0; fl[s] = 0; in_d[s] = '0;
      lvl_in[s] = '0; en_in[s] = 0;
    end
    lvl_wr = 0; en_wr = 0;
  endtask

  task automatic step(string ctx);
    model_next();
    @(negedge clk);
    check_all(ctx);
    idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle();
    for (int s = 0; s < 2; s++) begin
      m_cnt[s] = 0; m_err[s] = 0; m_lvl[s] = 7; m_en[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("reset R7");

    // R7 R9: enables only; thresholds must still be 7
    en_wr = 1; en_in[0] = 1; en_in[1] = 1;
    step("enable R9");          // tx req: 8 free >= 8
    in_v[0] = 1; in_d[0] = 16'h1111;
    step("tx one R7");          // 7 free, level 7 -> req low
    for (int i = 0; i < 7; i++) begin
      in_v[1] = 1; in_d[1] = 16'(16'hA000 + i);
      step("rx fill R6");
    end
    in_v[1] = 1; in_d[1] = 16'hA007;
    step("rx full R6");         // 8 filled -> req high
    // R8 push to full, pop tx to empty then pop empty
    in_v[1] = 1; in_d[1] = 16'hDEAD;
    step("rx overflow R8");
    step("rx err gone R8");
    out_r[0] = 1;
    step("tx drain R2");
    out_r[0] = 1;
    step("tx underflow R8");
    // R4 flush with colliding push
    fl[1] = 1; in_v[1] = 1; in_d[1] = 16'hBEEF; out_r[1] = 1;
    step("rx flush R4");
    // R9 level write alone keeps enables
    lvl_wr = 1; lvl_in[0] = 3'd0; lvl_in[1] = 3'd0;
    step("levels R9");

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int pv = (ph % 3 == 0) ? 90 : (ph % 3 == 1) ? 25 : 55;
      int pr = (ph % 3 == 0) ? 20 : (ph % 3 == 1) ? 85 : 50;
      for (int c = 0; c < 250; c++) begin
        for (int s = 0; s < 2; s++) begin
          in_v[s]  = ($urandom % 100) < pv;
          out_r[s] = ($urandom % 100) < pr;
          in_d[s]  = 16'($urandom);
          fl[s]    = ($urandom % 100) < 2;
          lvl_in[s] = 3'($urandom);
          en_in[s]  = ($urandom % 4) != 0;
        end
        lvl_wr = ($urandom % 100) < 5;
        en_wr  = ($urandom % 100) < 4;
        step("random");
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule